// File: doc/BRIEF.md
# Precision-Time Target Trigger and Pulse-Per-Second Generator

This block watches a free-running 64-bit precision time value, whose upper half counts seconds and whose lower half counts sub-seconds. Software loads a 64-bit target time. Once the running time is greater than or equal to that target, the block raises a dedicated trigger line and a sticky interrupt flag. The trigger line can also be routed to the input of a timer on the same clock. That timer can then timestamp the event with a fixed, known latency and no synchronizer uncertainty.

The block also drives a pulse-per-second pin. Each time the seconds field steps up by exactly one, the pin goes high for a fixed number of clock cycles. That number is derived from the clock frequency and a 125 ms high time. The pins of several nodes can then be compared on a scope to judge how well their clocks agree.

Top module: `ptp_trig_pps`

## Requirements
- R1: After reset, trigOut, timerTrig, intFlag and ppsOut are 0. No trigger fires until a target has been written with tgtWr, even if trigEn is 1.
- R2: When the trigger is armed and trigEn is 1, a clock edge that samples {sysSec,sysSub} greater than or equal to {tgtSec,tgtSub} sets trigOut at that edge. Equality fires.
- R3: A running time strictly below the target never sets trigOut. Lower seconds never fire, even with larger sub-seconds. Equal seconds with lower sub-seconds never fire.
- R4: Once set, trigOut stays 1 whatever the running time does, until an edge with tgtWr high. That edge loads the new target, clears trigOut and re-arms the trigger. The new target is compared from the following edge.
- R5: While trigEn is 0, an armed trigger does not fire. It stays armed and fires at the first edge with trigEn 1 and the time condition met.
- R6: intFlag goes to 1 at the same edge as trigOut. It stays 1 until an edge with intClr high. If the trigger fires on that same edge, the set wins.
- R7: timerTrig equals trigOut while routeSel is 0 and is 0 while routeSel is 1.
- R8: While ppsEn is 1, ppsOut rises at the edge where the sampled sysSec equals the previously sampled sysSec plus one.
- R9: Each pulse on ppsOut stays high for exactly CLK_HZ/1000*PPS_HIGH_MS clock cycles.
- R10: A seconds change other than +1 (a jump forward or backward) starts no pulse. While ppsEn is 0, ppsOut is 0 from the next edge onward and no pulse starts.
- R11: A +1 seconds step that arrives during a pulse restarts the full high time from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the time counter and the timer |
| rstN | input | 1 | Active-low synchronous reset |
| sysSec | input | SEC_W | Running time, seconds part |
| sysSub | input | SUB_W | Running time, sub-seconds part |
| tgtSec | input | SEC_W | Target time, seconds part, taken on tgtWr |
| tgtSub | input | SUB_W | Target time, sub-seconds part, taken on tgtWr |
| tgtWr | input | 1 | Loads the target and re-arms the trigger |
| trigEn | input | 1 | Enables the target comparison |
| intClr | input | 1 | Write-one-to-clear strobe for intFlag |
| routeSel | input | 1 | 0 routes the trigger to timerTrig, 1 blocks it |
| ppsEn | input | 1 | Enables the pulse-per-second output |
| trigOut | output | 1 | Registered trigger level |
| timerTrig | output | 1 | Trigger as seen by the internal timer input |
| intFlag | output | 1 | Sticky interrupt flag |
| ppsOut | output | 1 | Pulse-per-second pin |

## Verification
A lost or stuck armed state shows at the ports within a single cycle. Either trigOut fails to rise on the first edge that meets the target, or it rises with no target written or with the running time below it. A corrupted target register or a wrong comparison order is exposed by times that differ from the target in only one half, the seconds or the sub-seconds. A wrong high-time counter or a wrong seconds-step detector shows up on ppsOut. The pulse length is off by a counted number of cycles, or a pulse appears on a jump of the seconds field that should start none.

// File: rtl/ptp_trig_pkg.sv
package ptp_trig_pkg;

  typedef struct packed {
    logic loadTgt;
    logic ppsLoad;
    logic ppsDec;
  } ctrlStrobe_t;

endpackage

// File: rtl/ptp_trig_dp.sv
module ptp_trig_dp
  import ptp_trig_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32,
  parameter int CNT_W = 24,
  parameter int HIGH_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEC_W-1:0] sysSec,
  input  logic [SUB_W-1:0] sysSub,
  input  logic [SEC_W-1:0] tgtSec,
  input  logic [SUB_W-1:0] tgtSub,
  input  ctrlStrobe_t      strobe,
  output logic             timeReached,
  output logic             secTick,
  output logic             cntZero
);

  localparam int TIME_W = SEC_W + SUB_W;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HIGH_CYCLES - 1);

  logic [SEC_W-1:0] tgtSecQ;
  logic [SUB_W-1:0] tgtSubQ;
  logic [SEC_W-1:0] prevSec;
  logic             secValid;
  logic [CNT_W-1:0] ppsCnt;
  logic [TIME_W-1:0] nowTime;
  logic [TIME_W-1:0] tgtTime;

  // target time register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtSecQ <= '0;
      tgtSubQ <= '0;
    end else if (strobe.loadTgt) begin
      tgtSecQ <= tgtSec;
      tgtSubQ <= tgtSub;
    end
  end

  // unsigned compare with the seconds as the more significant half
  assign nowTime     = {sysSec, sysSub};
  assign tgtTime     = {tgtSecQ, tgtSubQ};
  assign timeReached = (nowTime >= tgtTime);

  // seconds-step detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSec  <= '0;
      secValid <= 1'b0;
    end else begin
      prevSec  <= sysSec;
      secValid <= 1'b1;
    end
  end

  assign secTick = secValid && (sysSec == prevSec + SEC_W'(1));

  // high-time counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ppsCnt <= '0;
    end else if (strobe.ppsLoad) begin
      ppsCnt <= CNT_LOAD;
    end else if (strobe.ppsDec && ppsCnt != '0) begin
      ppsCnt <= ppsCnt - CNT_W'(1);
    end
  end

  assign cntZero = (ppsCnt == '0);

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppsCnt <= CNT_LOAD);

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ppsLoad |=> ppsCnt == CNT_LOAD);

endmodule

// File: rtl/ptp_trig_ctrl.sv
module ptp_trig_ctrl
  import ptp_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tgtWr,
  input  logic        trigEn,
  input  logic        intClr,
  input  logic        ppsEn,
  input  logic        timeReached,
  input  logic        secTick,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        trigOut,
  output logic        intFlag,
  output logic        ppsOut
);

  logic armed;
  logic fireNow;

  assign fireNow = !tgtWr && armed && trigEn && timeReached;

  // trigger state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      trigOut <= 1'b0;
    end else if (tgtWr) begin
      armed   <= 1'b1;
      trigOut <= 1'b0;
    end else if (fireNow) begin
      armed   <= 1'b0;
      trigOut <= 1'b1;
    end
  end

  // sticky interrupt flag, set beats clear
  always_ff @(posedge clk) begin
    if (!rstN)        intFlag <= 1'b0;
    else if (fireNow) intFlag <= 1'b1;
    else if (intClr)  intFlag <= 1'b0;
  end

  // pulse-per-second sequencing
  always_comb begin
    strobe         = '0;
    strobe.loadTgt = tgtWr;
    if (ppsEn) begin
      if (secTick)                 strobe.ppsLoad = 1'b1;
      else if (ppsOut && !cntZero) strobe.ppsDec  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  ppsOut <= 1'b0;
    else if (!ppsEn)            ppsOut <= 1'b0;
    else if (secTick)           ppsOut <= 1'b1;
    else if (ppsOut && cntZero) ppsOut <= 1'b0;
  end

  // R4
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut && !tgtWr |=> trigOut);

  // R4
  trig_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtWr |=> !trigOut);

  // R5
  no_fire_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trigEn && !trigOut |=> !trigOut);

  // R6
  int_with_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |-> intFlag);

  // R6
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    intFlag && !intClr |=> intFlag);

  // R10
  pps_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ppsEn |=> !ppsOut);

  // R8
  pps_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ppsEn && secTick |=> ppsOut);

endmodule

// File: rtl/ptp_trig_pps.sv
module ptp_trig_pps
  import ptp_trig_pkg::*;
#(
  parameter int SEC_W       = 32,
  parameter int SUB_W       = 32,
  parameter int CLK_HZ      = 100_000_000,
  parameter int PPS_HIGH_MS = 125
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEC_W-1:0] sysSec,
  input  logic [SUB_W-1:0] sysSub,
  input  logic [SEC_W-1:0] tgtSec,
  input  logic [SUB_W-1:0] tgtSub,
  input  logic             tgtWr,
  input  logic             trigEn,
  input  logic             intClr,
  input  logic             routeSel,
  input  logic             ppsEn,
  output logic             trigOut,
  output logic             timerTrig,
  output logic             intFlag,
  output logic             ppsOut
);

  localparam int HIGH_CYCLES = (CLK_HZ / 1000) * PPS_HIGH_MS;
  localparam int CNT_W       = (HIGH_CYCLES > 1) ? $clog2(HIGH_CYCLES) : 1;

  ctrlStrobe_t strobe;
  logic        timeReached;
  logic        secTick;
  logic        cntZero;

  ptp_trig_dp #(
    .SEC_W       (SEC_W),
    .SUB_W       (SUB_W),
    .CNT_W       (CNT_W),
    .HIGH_CYCLES (HIGH_CYCLES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .sysSec      (sysSec),
    .sysSub      (sysSub),
    .tgtSec      (tgtSec),
    .tgtSub      (tgtSub),
    .strobe      (strobe),
    .timeReached (timeReached),
    .secTick     (secTick),
    .cntZero     (cntZero)
  );

  ptp_trig_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .tgtWr       (tgtWr),
    .trigEn      (trigEn),
    .intClr      (intClr),
    .ppsEn       (ppsEn),
    .timeReached (timeReached),
    .secTick     (secTick),
    .cntZero     (cntZero),
    .strobe      (strobe),
    .trigOut     (trigOut),
    .intFlag     (intFlag),
    .ppsOut      (ppsOut)
  );

  assign timerTrig = trigOut && !routeSel;

  // R7
  route_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    routeSel |-> !timerTrig);

  // R7
  route_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !routeSel |-> timerTrig == trigOut);

endmodule

// File: tb/ptp_trig_pps_tb.sv
module ptp_trig_pps_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int TB_CLK_HZ   = 8000;
  localparam int TB_HIGH_MS  = 125;
  localparam int EXP_HIGH    = 1000;   // 8 cycles per ms times 125 ms
  localparam int WATCHDOG    = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] sysSec = '0;
  logic [31:0] sysSub = '0;
  logic [31:0] tgtSec = '0;
  logic [31:0] tgtSub = '0;
  logic        tgtWr = 1'b0;
  logic        trigEn = 1'b0;
  logic        intClr = 1'b0;
  logic        routeSel = 1'b0;
  logic        ppsEn = 1'b0;
  logic        trigOut;
  logic        timerTrig;
  logic        intFlag;
  logic        ppsOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_trig_pps #(
    .SEC_W(32), .SUB_W(32), .CLK_HZ(TB_CLK_HZ), .PPS_HIGH_MS(TB_HIGH_MS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sysSec(sysSec), .sysSub(sysSub),
    .tgtSec(tgtSec), .tgtSub(tgtSub), .tgtWr(tgtWr), .trigEn(trigEn),
    .intClr(intClr), .routeSel(routeSel), .ppsEn(ppsEn),
    .trigOut(trigOut), .timerTrig(timerTrig), .intFlag(intFlag), .ppsOut(ppsOut)
  );

  task automatic check(string req, string what, longint actual, longint expected);
    nChecks++;
    if (actual != expected) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setTime(logic [31:0] s, logic [31:0] ss);
    sysSec = s;
    sysSub = ss;
  endtask

  task automatic writeTarget(logic [31:0] s, logic [31:0] ss);
    tgtSec = s;
    tgtSub = ss;
    tgtWr  = 1'b1;
    cyc(1);
    tgtWr  = 1'b0;
  endtask

  task automatic measureHigh(output int n);
    n = 1;
    while (ppsOut && n < EXP_HIGH + 20) begin
      cyc(1);
      if (ppsOut) n++;
    end
  endtask

  task automatic testReset();
    setTime(50, 7);
    trigEn = 1'b1;
    cyc(3);
    check("R1", "trigOut in reset", trigOut, 0);
    check("R1", "intFlag in reset", intFlag, 0);
    check("R1", "ppsOut in reset", ppsOut, 0);
    check("R1", "timerTrig in reset", timerTrig, 0);
    rstN = 1'b1;
    cyc(4);
    check("R1", "no fire without target", trigOut, 0);
    check("R1", "no flag without target", intFlag, 0);
  endtask

  task automatic testCompare();
    routeSel = 1'b0;
    setTime(10, 99);
    writeTarget(10, 100);
    check("R4", "cleared at write edge", trigOut, 0);
    cyc(1);
    check("R3", "sub-seconds one below", trigOut, 0);
    setTime(9, 32'hFFFF_FFFF);
    cyc(2);
    check("R3", "seconds below, sub above", trigOut, 0);
    setTime(10, 100);
    cyc(1);
    check("R2", "fire on equality", trigOut, 1);
    check("R6", "flag with trigger", intFlag, 1);
    check("R7", "timerTrig follows when routed", timerTrig, 1);
  endtask

  task automatic testHold();
    setTime(5, 0);
    cyc(3);
    check("R4", "trigger held after time drops", trigOut, 1);
    intClr = 1'b1;
    cyc(1);
    intClr = 1'b0;
    check("R6", "flag cleared by write-one", intFlag, 0);
    cyc(2);
    check("R6", "flag stays clear", intFlag, 0);
    routeSel = 1'b1;
    cyc(1);
    check("R7", "timerTrig blocked", timerTrig, 0);
    check("R4", "trigOut unaffected by route", trigOut, 1);
    routeSel = 1'b0;
  endtask

  task automatic testRearm();
    trigEn = 1'b0;
    writeTarget(20, 0);
    check("R4", "re-arm clears trigger", trigOut, 0);
    setTime(20, 1);
    cyc(3);
    check("R5", "no fire while disabled", trigOut, 0);
    trigEn = 1'b1;
    intClr = 1'b1;
    cyc(1);
    intClr = 1'b0;
    check("R5", "fires once enabled", trigOut, 1);
    check("R6", "set wins over clear", intFlag, 1);
    writeTarget(1, 0);
    check("R4", "write clears with time past target", trigOut, 0);
    cyc(1);
    check("R4", "new target compared next edge", trigOut, 1);
  endtask

  task automatic testPps();
    int n;
    ppsEn = 1'b1;
    setTime(100, 0);
    cyc(3);
    check("R8", "no pulse with steady seconds", ppsOut, 0);
    setTime(101, 5);
    cyc(1);
    check("R8", "pulse on seconds step", ppsOut, 1);
    measureHigh(n);
    check("R9", "high time in cycles", n, EXP_HIGH);
    setTime(103, 0);
    cyc(3);
    check("R10", "no pulse on jump forward", ppsOut, 0);
    setTime(50, 0);
    cyc(3);
    check("R10", "no pulse on jump back", ppsOut, 0);
    ppsEn = 1'b0;
    setTime(51, 0);
    cyc(3);
    check("R10", "no pulse while disabled", ppsOut, 0);
    ppsEn = 1'b1;
    cyc(2);
    check("R10", "no late pulse after enable", ppsOut, 0);
    setTime(52, 0);
    cyc(1);
    check("R8", "second pulse starts", ppsOut, 1);
    cyc(10);
    ppsEn = 1'b0;
    cyc(1);
    check("R10", "disable cuts pulse", ppsOut, 0);
    ppsEn = 1'b1;
    cyc(2);
    setTime(53, 0);
    cyc(101);
    check("R11", "pulse high before restart", ppsOut, 1);
    setTime(54, 0);
    cyc(1);
    measureHigh(n);
    check("R11", "full high time after restart", n, EXP_HIGH);
    cyc(2);
    check("R9", "low after pulse", ppsOut, 0);
  endtask

  initial begin
    cyc(1);
    testReset();
    testCompare();
    testHold();
    testRearm();
    testPps();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule